// File: doc/BRIEF.md
# Prescaled PWM Channel with Edge Compare and Watchdog Duty Override

This block produces one pulse-width-modulated output from a fast system clock. A prescaler made of a power-of-two stage followed by a linear stage slows the clock into counting ticks. An 8-bit counter steps through one output cycle on those ticks. Two independent compare points set where the output goes high and where it goes low. Polarity inversion, a static-level override and separate gating of the counting clock and of the output pin complete the output path.

Configuration arrives through two 32-bit register images, a control word and a compare word. Each is loaded by a single-cycle write strobe. New compare points can be held back until the current output cycle ends, or applied at once. A watchdog event input can make the block switch to a preset fall point. The switch happens on a rising or falling output edge chosen by the control word. The block is meant to be repeated once per channel behind a register decoder that sits outside it.

Top module: `pwm_chan_gen`

## Requirements
- R1: In the cycle after reset is released, `pwm_o` and `pwm_oe` are both 0.
- R2: With the clock-enable bit (control bit 16) set, the period counter advances once every 2^E × (L + 1) system clocks. E is control bits 11:8 and L is control bits 7:0. The counter returns to 0 after reaching the period value P (compare bits 31:24), so one output cycle lasts (P + 1) × 2^E × (L + 1) clocks.
- R3: The internal level is set when the counter equals the rise point (compare bits 7:0) and cleared when the counter equals the fall point (compare bits 15:8). When the two points are equal, the clear wins and the level stays low. A fall point above P leaves the level high from the rise point onward.
- R4: While control bit 16 is clear, the prescaler, the period counter and the level are held at 0, and the compare points follow the compare register directly.
- R5: `pwm_oe` equals control bit 12, delayed by one clock. While bit 12 is clear, `pwm_o` is held at the inactive level, which is 0 before inversion.
- R6: Control bit 14 inverts `pwm_o`, including the inactive level.
- R7: With control bit 17 clear, newly written compare points take effect only at the period boundary, which is the tick on which the counter wraps to 0.
- R8: With control bit 17 set, the compare points take effect on the clock after the compare register is written.
- R9: With control bit 18 set, a pulse on `wdt_evt` arms a pending reload. The reload is applied on the next falling level edge if control bit 19 is 0, or on the next rising level edge if it is 1. From then on, compare bits 23:16 replace the fall point until bit 18 or bit 16 is cleared.
- R10: Control bit 15 forces the pre-inversion output high while the channel clock is enabled. It has no effect while bit 16 is clear.
- R11: `pwm_o` is registered. It reflects the level one clock after the level changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Write strobe for the control register |
| ctrl_wdata | input | 32 | Control register write data |
| cmp_we | input | 1 | Write strobe for the compare register |
| cmp_wdata | input | 32 | Compare register write data |
| wdt_evt | input | 1 | Watchdog event pulse |
| pwm_o | output | 1 | PWM output level |
| pwm_oe | output | 1 | Output enable for the pad |

## Verification
The bench builds the block with its default widths: a 4-bit exponent, an 8-bit linear divider and an 8-bit period counter. It exercises small divider settings (E = 1, L = 1, and E = 0, L = 0) together with short periods. This brings full output cycles, period wraps, shadowed compare loads and both watchdog edge choices within a few hundred clocks each. It also allows an exact measurement of the interval between rising edges. Large exponents are not reached in cycles; the interval check at small settings, together with the cycle-by-cycle model comparison, covers the divider arithmetic.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;
  // control word bit positions (decoded by the register layer above)
  localparam int unsigned CTL_DIVL_LSB  = 0;
  localparam int unsigned CTL_DIVH_LSB  = 8;
  localparam int unsigned CTL_PIN_EN    = 12;
  localparam int unsigned CTL_INVERT    = 14;
  localparam int unsigned CTL_FORCE     = 15;
  localparam int unsigned CTL_CLK_EN    = 16;
  localparam int unsigned CTL_NO_SYNC   = 17;
  localparam int unsigned CTL_WD_EN     = 18;
  localparam int unsigned CTL_WD_RISE   = 19;
  // compare word field positions
  localparam int unsigned CMP_RISE_LSB  = 0;
  localparam int unsigned CMP_FALL_LSB  = 8;
  localparam int unsigned CMP_WDF_LSB   = 16;
  localparam int unsigned CMP_PER_LSB   = 24;
  localparam int unsigned REG_W         = 32;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int unsigned EXP_W = 4,
  parameter int unsigned LIN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [EXP_W-1:0] div_exp,
  input  logic [LIN_W-1:0] div_lin,
  output logic             tick
);
  localparam int unsigned HW = (1 << EXP_W) - 1;

  logic [HW-1:0] pow_q;
  logic [LIN_W-1:0] lin_q;
  logic [HW:0] pow_lim_w;
  logic pow_wrap, lin_wrap;

  assign pow_lim_w = ((HW+1)'(1) << div_exp) - (HW+1)'(1);
  assign pow_wrap  = pow_q >= pow_lim_w[HW-1:0];
  assign lin_wrap  = lin_q >= div_lin;
  assign tick      = en && pow_wrap && lin_wrap;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      pow_q <= '0;
      lin_q <= '0;
    end else begin
      pow_q <= pow_wrap ? '0 : pow_q + 1'b1;
      if (pow_wrap) lin_q <= lin_wrap ? '0 : lin_q + 1'b1;
    end
  end
endmodule

// File: rtl/pwm_edge_gen.sv
module pwm_edge_gen #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             tick,
  input  logic             no_sync,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] rise_in,
  input  logic [CNT_W-1:0] fall_in,
  input  logic [CNT_W-1:0] wd_fall,
  input  logic             wd_on,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] rise_a,
  output logic             lvl_q,
  output logic             boundary,
  output logic             rise_ev,
  output logic             fall_ev
);
  logic [CNT_W-1:0] fall_a, fall_eff;
  logic lvl_n, load;

  assign boundary = tick && (cnt_q >= period);
  assign load     = !en || no_sync || boundary;
  assign fall_eff = wd_on ? wd_fall : fall_a;

  always_comb begin
    lvl_n = lvl_q;
    if (!en)                    lvl_n = 1'b0;
    else if (cnt_q == fall_eff) lvl_n = 1'b0;
    else if (cnt_q == rise_a)   lvl_n = 1'b1;
  end

  assign rise_ev = !lvl_q && lvl_n;
  assign fall_ev = lvl_q && !lvl_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      rise_a <= '0;
      fall_a <= '0;
      lvl_q  <= 1'b0;
    end else begin
      if (!en)      cnt_q <= '0;
      else if (tick) cnt_q <= boundary ? '0 : cnt_q + 1'b1;
      if (load) begin
        rise_a <= rise_in;
        fall_a <= fall_in;
      end
      lvl_q <= lvl_n;
    end
  end
endmodule

// File: rtl/pwm_wd_reload.sv
module pwm_wd_reload (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic evt,
  input  logic on_rise,
  input  logic rise_ev,
  input  logic fall_ev,
  output logic pend_q,
  output logic on_q
);
  logic apply;
  assign apply = pend_q && (on_rise ? rise_ev : fall_ev);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      pend_q <= 1'b0;
      on_q   <= 1'b0;
    end else begin
      pend_q <= evt || (pend_q && !apply);
      on_q   <= on_q || apply;
    end
  end
endmodule

// File: rtl/pwm_chan_gen.sv
module pwm_chan_gen
  import pwm_chan_pkg::*;
#(
  parameter int unsigned EXP_W = 4,
  parameter int unsigned LIN_W = 8,
  parameter int unsigned CNT_W = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ctrl_we,
  input  logic [31:0] ctrl_wdata,
  input  logic        cmp_we,
  input  logic [31:0] cmp_wdata,
  input  logic        wdt_evt,
  output logic        pwm_o,
  output logic        pwm_oe
);
  logic [REG_W-1:0] ctrl_q, cmp_q;
  logic ce, pin_en, inv, force_hi, no_sync, wd_en, wd_rise;
  logic tick, boundary, lvl_q, rise_ev, fall_ev, pend_q, wd_on, raw;
  logic [CNT_W-1:0] cnt_q, rise_a;

  assign ce       = ctrl_q[CTL_CLK_EN];
  assign pin_en   = ctrl_q[CTL_PIN_EN];
  assign inv      = ctrl_q[CTL_INVERT];
  assign force_hi = ctrl_q[CTL_FORCE];
  assign no_sync  = ctrl_q[CTL_NO_SYNC];
  assign wd_en    = ctrl_q[CTL_WD_EN];
  assign wd_rise  = ctrl_q[CTL_WD_RISE];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      cmp_q  <= '0;
    end else begin
      if (ctrl_we) ctrl_q <= ctrl_wdata;
      if (cmp_we)  cmp_q  <= cmp_wdata;
    end
  end

  pwm_prescaler #(.EXP_W(EXP_W), .LIN_W(LIN_W)) u_pre (
    .clk(clk), .rst(rst), .en(ce),
    .div_exp(ctrl_q[CTL_DIVH_LSB +: EXP_W]),
    .div_lin(ctrl_q[CTL_DIVL_LSB +: LIN_W]),
    .tick(tick)
  );

  pwm_edge_gen #(.CNT_W(CNT_W)) u_edge (
    .clk(clk), .rst(rst), .en(ce), .tick(tick), .no_sync(no_sync),
    .period(cmp_q[CMP_PER_LSB +: CNT_W]),
    .rise_in(cmp_q[CMP_RISE_LSB +: CNT_W]),
    .fall_in(cmp_q[CMP_FALL_LSB +: CNT_W]),
    .wd_fall(cmp_q[CMP_WDF_LSB +: CNT_W]),
    .wd_on(wd_on),
    .cnt_q(cnt_q), .rise_a(rise_a), .lvl_q(lvl_q), .boundary(boundary),
    .rise_ev(rise_ev), .fall_ev(fall_ev)
  );

  pwm_wd_reload u_wd (
    .clk(clk), .rst(rst), .en(ce && wd_en), .evt(wdt_evt), .on_rise(wd_rise),
    .rise_ev(rise_ev), .fall_ev(fall_ev), .pend_q(pend_q), .on_q(wd_on)
  );

  assign raw = ce && (force_hi || lvl_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_o  <= 1'b0;
      pwm_oe <= 1'b0;
    end else begin
      pwm_o  <= pin_en ? (raw ^ inv) : inv;
      pwm_oe <= pin_en;
    end
  end
endmodule

// File: rtl/pwm_chan_chk.sv
module pwm_chan_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             ce,
  input logic             pin_en,
  input logic             inv,
  input logic             force_hi,
  input logic             no_sync,
  input logic             tick,
  input logic             boundary,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] rise_a,
  input logic             pend_q,
  input logic             wd_on,
  input logic             pwm_o,
  input logic             pwm_oe
);
  // R4
  cnt_clr_chk: assert property (@(posedge clk) disable iff (rst)
    !ce |=> (cnt_q == '0));
  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ce && !tick) |=> $stable(cnt_q));
  // R5
  pin_off_chk: assert property (@(posedge clk) disable iff (rst)
    !pin_en |=> (!pwm_oe && pwm_o == $past(inv)));
  // R6
  inv_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (pin_en && !ce) |=> (pwm_oe && pwm_o == $past(inv)));
  // R10
  force_chk: assert property (@(posedge clk) disable iff (rst)
    (pin_en && ce && force_hi) |=> (pwm_o == !$past(inv)));
  // R7
  shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ce && !no_sync && !boundary) |=> $stable(rise_a));
  // R9
  wd_arm_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(wd_on) |-> $past(pend_q));
endmodule

bind pwm_chan_gen pwm_chan_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .ce(ce), .pin_en(pin_en), .inv(inv),
  .force_hi(force_hi), .no_sync(no_sync), .tick(tick), .boundary(boundary),
  .cnt_q(cnt_q), .rise_a(rise_a), .pend_q(pend_q), .wd_on(wd_on),
  .pwm_o(pwm_o), .pwm_oe(pwm_oe)
);

// File: tb/test_pwm_chan_gen.sv
module test_pwm_chan_gen;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ctrl_we = 1'b0, cmp_we = 1'b0, wdt_evt = 1'b0;
  logic [31:0] ctrl_wdata = '0, cmp_wdata = '0;
  logic pwm_o, pwm_oe;
  int checks = 0, errs = 0, cyc = 0;
  string req = "R1";

  always #5 clk = ~clk;

  pwm_chan_gen i_pwm_chan_gen (
    .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .cmp_we(cmp_we), .cmp_wdata(cmp_wdata), .wdt_evt(wdt_evt),
    .pwm_o(pwm_o), .pwm_oe(pwm_oe)
  );

  // behavioural reference model, one step per clock
  logic [31:0] m_ctrl, m_cmp;
  int m_div_cnt, m_cnt, m_rise, m_fall;
  logic m_lvl, m_pend, m_wdon, m_out, m_oe;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      m_ctrl = 0; m_cmp = 0; m_div_cnt = 0; m_cnt = 0; m_rise = 0; m_fall = 0;
      m_lvl = 0; m_pend = 0; m_wdon = 0; m_out = 0; m_oe = 0;
    end else begin
      bit en, nsy, wde, go, bnd, nl, rev, fev, app, wd_clr;
      int div, per, fe, nd, nc;
      en  = m_ctrl[16];
      nsy = m_ctrl[17];
      wde = m_ctrl[18];
      div = (1 << m_ctrl[11:8]) * (int'(m_ctrl[7:0]) + 1);
      per = int'(m_cmp[31:24]);
      go  = en && (m_div_cnt == div - 1);
      bnd = go && (m_cnt >= per);
      nd  = (!en || m_div_cnt >= div - 1) ? 0 : m_div_cnt + 1;
      nc  = !en ? 0 : (go ? (bnd ? 0 : m_cnt + 1) : m_cnt);
      fe  = m_wdon ? int'(m_cmp[23:16]) : m_fall;
      if (!en) nl = 0;
      else if (m_cnt == fe) nl = 0;
      else if (m_cnt == m_rise) nl = 1;
      else nl = m_lvl;
      rev = !m_lvl && nl;
      fev = m_lvl && !nl;
      app = m_pend && (m_ctrl[19] ? rev : fev);
      wd_clr = !en || !wde;
      m_oe  = m_ctrl[12];
      m_out = m_ctrl[12] ? ((en && (m_ctrl[15] || m_lvl)) ^ m_ctrl[14]) : m_ctrl[14];
      m_pend = wd_clr ? 0 : (wdt_evt || (m_pend && !app));
      m_wdon = wd_clr ? 0 : (m_wdon || app);
      if (!en || nsy || bnd) begin
        m_rise = int'(m_cmp[7:0]);
        m_fall = int'(m_cmp[15:8]);
      end
      m_lvl = nl;
      m_div_cnt = nd;
      m_cnt = nc;
      if (ctrl_we) m_ctrl = ctrl_wdata;
      if (cmp_we)  m_cmp  = cmp_wdata;
    end
  end

  always @(negedge clk) begin
    checks++;
    if (pwm_o !== m_out || pwm_oe !== m_oe) begin
      errs++;
      $display("FAIL %s: pwm_o=%b pwm_oe=%b expected pwm_o=%b pwm_oe=%b (cycle %0d)",
               req, pwm_o, pwm_oe, m_out, m_oe, cyc);
    end
  end

  function automatic logic [31:0] mk_ctrl(bit ce, bit pin, bit inv, bit frc,
      bit nsy, bit wde, bit wrise, int e, int l);
    logic [31:0] v = '0;
    v[16] = ce; v[12] = pin; v[14] = inv; v[15] = frc;
    v[17] = nsy; v[18] = wde; v[19] = wrise;
    v[11:8] = 4'(e); v[7:0] = 8'(l);
    return v;
  endfunction

  function automatic logic [31:0] mk_cmp(int per, int wdf, int fall, int rise);
    return {8'(per), 8'(wdf), 8'(fall), 8'(rise)};
  endfunction

  task automatic put_ctrl(logic [31:0] v);
    @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = v;
    @(negedge clk); ctrl_we = 1'b0;
  endtask

  task automatic put_cmp(logic [31:0] v);
    @(negedge clk); cmp_we = 1'b1; cmp_wdata = v;
    @(negedge clk); cmp_we = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rise_interval(output int d);
    logic p;
    int t0;
    p = pwm_o;
    do begin @(negedge clk); if (pwm_o && !p) break; p = pwm_o; end while (1);
    t0 = cyc;
    p = pwm_o;
    do begin @(negedge clk); if (pwm_o && !p) break; p = pwm_o; end while (1);
    d = cyc - t0;
  endtask

  initial begin
    int d;
    req = "R1";
    idle(3);
    rst = 1'b0;
    idle(2);
    // R1: explicit reset-state check
    checks++;
    if (pwm_o !== 1'b0 || pwm_oe !== 1'b0) begin
      errs++;
      $display("FAIL R1: pwm_o=%b pwm_oe=%b expected 0 0", pwm_o, pwm_oe);
    end

    req = "R4"; // pin on, counting clock off
    put_ctrl(mk_ctrl(0, 1, 0, 0, 0, 0, 0, 1, 1));
    put_cmp(mk_cmp(9, 0, 6, 2));
    idle(10);

    req = "R2"; // E=1, L=1, P=9 gives 40 clocks per output cycle
    put_ctrl(mk_ctrl(1, 1, 0, 0, 0, 0, 0, 1, 1));
    idle(100);
    rise_interval(d);
    checks++;
    if (d != 40) begin
      errs++;
      $display("FAIL R2: rise interval=%0d expected 40", d);
    end

    req = "R3"; // fall above period: high from rise point on
    put_cmp(mk_cmp(9, 0, 20, 3));
    idle(120);
    req = "R3"; // equal points: stays low
    put_cmp(mk_cmp(9, 0, 5, 5));
    idle(120);

    req = "R6";
    put_cmp(mk_cmp(9, 0, 6, 2));
    put_ctrl(mk_ctrl(1, 1, 1, 0, 0, 0, 0, 1, 1));
    idle(100);

    req = "R7"; // shadowed update mid-cycle
    put_ctrl(mk_ctrl(1, 1, 0, 0, 0, 0, 0, 0, 1));
    idle(7);
    put_cmp(mk_cmp(9, 0, 8, 1));
    idle(60);

    req = "R8"; // immediate update
    put_ctrl(mk_ctrl(1, 1, 0, 0, 1, 0, 0, 0, 1));
    idle(5);
    put_cmp(mk_cmp(9, 0, 4, 0));
    idle(60);

    req = "R11";
    put_ctrl(mk_ctrl(1, 1, 0, 0, 0, 0, 0, 0, 0));
    idle(40);

    req = "R10"; // force with clock on, then with clock off
    put_ctrl(mk_ctrl(1, 1, 0, 1, 0, 0, 0, 0, 0));
    idle(20);
    put_ctrl(mk_ctrl(0, 1, 0, 1, 0, 0, 0, 0, 0));
    idle(20);

    req = "R9"; // watchdog reload on falling edge
    put_cmp(mk_cmp(255, 50, 200, 0));
    put_ctrl(mk_ctrl(1, 1, 0, 0, 0, 1, 0, 0, 0));
    idle(30);
    @(negedge clk); wdt_evt = 1'b1;
    @(negedge clk); wdt_evt = 1'b0;
    idle(600);
    req = "R9"; // rising-edge select after re-arm
    put_ctrl(mk_ctrl(1, 1, 0, 0, 0, 0, 1, 0, 0));
    put_ctrl(mk_ctrl(1, 1, 0, 0, 0, 1, 1, 0, 0));
    idle(100);
    @(negedge clk); wdt_evt = 1'b1;
    @(negedge clk); wdt_evt = 1'b0;
    idle(600);

    req = "R4"; // clock enable dropped mid-run
    put_ctrl(mk_ctrl(0, 1, 0, 0, 0, 1, 1, 0, 0));
    idle(20);

    req = "R5"; // pin disabled, with and without inversion
    put_ctrl(mk_ctrl(1, 0, 0, 0, 0, 0, 0, 0, 0));
    idle(30);
    put_ctrl(mk_ctrl(1, 0, 1, 0, 0, 0, 0, 0, 0));
    idle(30);

    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: run did not complete, expected finish before 150000 cycles");
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end
endmodule